// File: doc/BRIEF.md
# Cache Way Power-Down Controller

This controller decides how many ways of a set-associative second-level cache stay powered while a core moves between running and a deep low-power sleep. Enabled ways always form a contiguous group starting at way 0. Each time the core asks to sleep, the controller may take ways out of service by a programmable step. It removes them one at a time from the highest enabled index downward. For each one it asks for a flush and waits for that way's flush-done reply before clearing its enable bit.

Two things can block shrinking at a sleep entry:
- a running-state residency timer that has reached its reload value;
- a bus-to-core clock ratio that is not below the shrink threshold. A ratio of zero is never taken into account.

A shrink-prevention hint carried with the sleep request also blocks it. When the ratio is above the threshold, or the residency timer has expired, an expansion request is raised. The next interrupt seen while running then re-enables every way.

Waking from sleep raises the cache to two ways if it was smaller. Ways that come back into service are flagged for invalidation by a one-cycle pulse. The deepest sleep level is only allowed while asleep with no way enabled.

Top module: `way_gate_ctrl`

## Requirements
- R1: After reset, all WAYS ways are enabled, and `flush_req`, `inval_req` and `deep_ok` are zero. The residency timer starts from zero with reload value TIMER_DEF, and the latched threshold is all ones.
- R2: A `sleep_req` accepted while running starts a shrink when all of these hold:
  - `keep_full` is low;
  - the residency timer has not expired;
  - `clk_ratio` is zero or below `shrink_thresh`.
  
  The target count is the current count minus `shrink_step`, saturating at zero. If the target equals the current count, the block goes straight to sleep.
- R3: During a shrink, `flush_req` is one-hot on way count-1, the highest enabled way. That way's enable bit clears at the clock edge where `flush_done` for that way is high. Flush-done bits of other ways have no effect. Enabled ways always stay contiguous from way 0.
- R4: A ratio equal to the threshold blocks shrinking. `expand_req` is high exactly when fewer than WAYS ways are enabled and either the timer has expired or `clk_ratio` is nonzero and above the latched threshold. With a ratio equal to the threshold, `expand_req` stays low.
- R5: The residency timer counts clock edges spent in the running state and is cleared at each accepted sleep entry. It expires once the count reaches the latched reload value. Expiry blocks shrinking at the next entry and raises `expand_req` when the cache is not full.
- R6: An `irq` seen while running with `expand_req` high enables all ways on the next cycle. At the same time `inval_req` pulses for one cycle with the bits of the ways that were disabled. An `irq` without `expand_req` has no effect.
- R7: A `wake` pulse while asleep returns the block to running. If fewer than two ways were enabled, ways 0 and 1 become enabled and `inval_req` pulses for one cycle on those that were off. Otherwise the mask is unchanged and `inval_req` stays zero.
- R8: `deep_ok` is high exactly while asleep with zero ways enabled.
- R9: With `keep_full` high at sleep entry, no way is flushed or disabled and `deep_ok` stays low.
- R10: Two values are latched at the accepted sleep entry and used until the next one: the threshold used for `expand_req`, and the timer reload value. Later changes on `shrink_thresh` do not alter `expand_req`.
- R11: `sleep_req` is ignored unless running, and `wake` is ignored unless asleep. When `sleep_req` and `irq` arrive together while running, the sleep entry wins and the interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle deep-sleep entry request |
| keep_full | input | 1 | Shrink-prevention hint, sampled with `sleep_req` |
| wake | input | 1 | One-cycle stop-clock release, ends sleep |
| irq | input | 1 | Interrupt strobe |
| clk_ratio | input | RATIO_W | Bus-to-core clock ratio, zero means unknown |
| shrink_thresh | input | RATIO_W | Shrink threshold, latched at entry |
| shrink_step | input | CNT_W | Ways to remove per entry, latched at entry |
| timer_reload | input | TIMER_W | Residency timer limit, latched at entry |
| flush_done | input | WAYS | Per-way flush completion |
| way_en | output | WAYS | Enabled-way mask |
| flush_req | output | WAYS | Per-way flush request, one-hot during a shrink |
| inval_req | output | WAYS | One-cycle per-way invalidate pulse |
| deep_ok | output | 1 | Deepest sleep level allowed |
| expand_req | output | 1 | Cache expansion requested |

## Verification
The outputs `way_en`, `flush_req`, `inval_req` and `deep_ok` are registered. They change at the first rising edge that samples the stimulus (entry, flush-done, wake or interrupt). The `inval_req` pulse falls again one edge later. `expand_req` depends combinationally on the current ratio and on registered state, so it is valid in the same cycle a ratio change is driven. Inputs are driven and outputs sampled at the falling edge, so each check sees exactly the state after the intended rising edge. The reference model counts running-state edges to predict the exact edge at which the residency timer expires.

// File: rtl/way_gate_pkg.sv
package way_gate_pkg;
    parameter int WAYS      = 8;
    parameter int RATIO_W   = 6;
    parameter int TIMER_W   = 12;
    parameter int TIMER_DEF = 2000;
    localparam int CNT_W = $clog2(WAYS + 1);
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef enum logic [1:0] {ST_RUN, ST_SHRINK, ST_SLEEP} wg_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]   step;
        logic [RATIO_W-1:0] thresh;
        logic [TIMER_W-1:0] reload;
    } sleep_cfg_t;

    function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (b >= a) ? '0 : a - b;
    endfunction

    function automatic logic [WAYS-1:0] low_mask(input logic [CNT_W-1:0] n);
        logic [WAYS-1:0] m;
        for (int i = 0; i < WAYS; i++) m[i] = (i < int'(n));
        return m;
    endfunction
endpackage

// File: rtl/wg_res_timer.sv
module wg_res_timer
    import way_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               clear,
    input  logic [TIMER_W-1:0] reload_in,
    output logic               expired
);
    logic [TIMER_W-1:0] cnt_q;
    logic [TIMER_W-1:0] reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= TIMER_W'(TIMER_DEF);
        end else if (clear) begin
            cnt_q    <= '0;
            reload_q <= reload_in;
        end else if (run && (cnt_q < reload_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= reload_q);

    // R5
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= reload_q);

    // R5
    expiry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !clear) |=> expired);
endmodule

// File: rtl/wg_ratio_judge.sv
module wg_ratio_judge
    import way_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RATIO_W-1:0] thresh_in,
    output logic               entry_ok,
    output logic               ratio_hi
);
    logic [RATIO_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst)       thr_q <= '1;
        else if (load) thr_q <= thresh_in;
    end

    assign entry_ok = (ratio == '0) || (ratio < thresh_in);
    assign ratio_hi = (ratio != '0) && (ratio > thr_q);

    // R4
    zero_ratio_neutral_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio == '0) |-> (entry_ok && !ratio_hi));
endmodule

// File: rtl/wg_way_seq.sv
module wg_way_seq
    import way_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             keep_full,
    input  logic             wake,
    input  logic             irq,
    input  logic             entry_ok,
    input  logic             ratio_hi,
    input  logic             expired,
    input  logic [CNT_W-1:0] step,
    input  logic [WAYS-1:0]  flush_done,
    output logic             running,
    output logic             entry,
    output logic [WAYS-1:0]  way_en,
    output logic [WAYS-1:0]  flush_req,
    output logic [WAYS-1:0]  inval_req,
    output logic             deep_ok,
    output logic             expand_req
);
    wg_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  tgt_q;
    logic [WAYS-1:0]   mask_q;
    logic [WAYS-1:0]   inval_q;
    logic [CNT_W-1:0]  tgt_next;
    logic [IDX_W-1:0]  cur_idx;
    logic              shrink_go;
    logic              past_vld;

    assign running    = (state_q == ST_RUN);
    assign entry      = running && sleep_req;
    assign tgt_next   = sat_sub(cnt_q, step);
    assign shrink_go  = !keep_full && !expired && entry_ok && (tgt_next != cnt_q);
    assign cur_idx    = IDX_W'(cnt_q - CNT_W'(1));
    assign expand_req = (cnt_q != CNT_W'(WAYS)) && (expired || ratio_hi);
    assign deep_ok    = (state_q == ST_SLEEP) && (cnt_q == '0);
    assign way_en     = mask_q;
    assign inval_req  = inval_q;

    always_comb begin
        flush_req = '0;
        if (state_q == ST_SHRINK) flush_req[cur_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_W'(WAYS);
            tgt_q   <= '0;
            mask_q  <= '1;
            inval_q <= '0;
        end else begin
            inval_q <= '0;
            case (state_q)
                ST_RUN: begin
                    if (sleep_req) begin
                        if (shrink_go) begin
                            tgt_q   <= tgt_next;
                            state_q <= ST_SHRINK;
                        end else begin
                            state_q <= ST_SLEEP;
                        end
                    end else if (irq && expand_req) begin
                        mask_q  <= '1;
                        cnt_q   <= CNT_W'(WAYS);
                        inval_q <= ~mask_q;
                    end
                end
                ST_SHRINK: begin
                    if (flush_done[cur_idx]) begin
                        mask_q[cur_idx] <= 1'b0;
                        cnt_q           <= cnt_q - CNT_W'(1);
                        if ((cnt_q - CNT_W'(1)) == tgt_q) state_q <= ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (wake) begin
                        state_q <= ST_RUN;
                        if (cnt_q < CNT_W'(2)) begin
                            cnt_q   <= CNT_W'(2);
                            mask_q  <= mask_q | low_mask(CNT_W'(2));
                            inval_q <= low_mask(CNT_W'(2)) & ~mask_q;
                        end
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_vld <= 1'b0;
        else     past_vld <= 1'b1;
    end

    // R3
    flush_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flush_req));

    // R3
    mask_contig_chk: assert property (@(posedge clk) disable iff (rst)
        ((way_en + 1'b1) & way_en) == '0);

    // R3
    drop_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        (past_vld && (($past(way_en) & ~way_en) != '0)) |->
        (($past(way_en) & ~way_en) == ($past(flush_done) & $past(flush_req))));

    // R8
    deep_empty_chk: assert property (@(posedge clk) disable iff (rst)
        deep_ok |-> (way_en == '0));

    // R6
    inval_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (inval_req & ~way_en) == '0);
endmodule

// File: rtl/way_gate_ctrl.sv
module way_gate_ctrl
    import way_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               keep_full,
    input  logic               wake,
    input  logic               irq,
    input  logic [RATIO_W-1:0] clk_ratio,
    input  logic [RATIO_W-1:0] shrink_thresh,
    input  logic [CNT_W-1:0]   shrink_step,
    input  logic [TIMER_W-1:0] timer_reload,
    input  logic [WAYS-1:0]    flush_done,
    output logic [WAYS-1:0]    way_en,
    output logic [WAYS-1:0]    flush_req,
    output logic [WAYS-1:0]    inval_req,
    output logic               deep_ok,
    output logic               expand_req
);
    sleep_cfg_t cfg_in;
    logic       running;
    logic       entry;
    logic       expired;
    logic       entry_ok;
    logic       ratio_hi;

    assign cfg_in = '{step: shrink_step, thresh: shrink_thresh, reload: timer_reload};

    wg_res_timer timer_i (
        .clk       (clk),
        .rst       (rst),
        .run       (running && !entry),
        .clear     (entry),
        .reload_in (cfg_in.reload),
        .expired   (expired)
    );

    wg_ratio_judge ratio_i (
        .clk       (clk),
        .rst       (rst),
        .load      (entry),
        .ratio     (clk_ratio),
        .thresh_in (cfg_in.thresh),
        .entry_ok  (entry_ok),
        .ratio_hi  (ratio_hi)
    );

    wg_way_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .keep_full  (keep_full),
        .wake       (wake),
        .irq        (irq),
        .entry_ok   (entry_ok),
        .ratio_hi   (ratio_hi),
        .expired    (expired),
        .step       (cfg_in.step),
        .flush_done (flush_done),
        .running    (running),
        .entry      (entry),
        .way_en     (way_en),
        .flush_req  (flush_req),
        .inval_req  (inval_req),
        .deep_ok    (deep_ok),
        .expand_req (expand_req)
    );
endmodule

// File: tb/way_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module way_gate_ctrl_tb_top;
    import way_gate_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sleep_req = 1'b0, keep_full = 1'b0, wake = 1'b0, irq = 1'b0;
    logic [RATIO_W-1:0] clk_ratio = '0, shrink_thresh = '0;
    logic [CNT_W-1:0]   shrink_step = '0;
    logic [TIMER_W-1:0] timer_reload = '0;
    logic [WAYS-1:0]    flush_done = '0;
    logic [WAYS-1:0]    way_en, flush_req, inval_req;
    logic               deep_ok, expand_req;

    way_gate_ctrl dut_i (.*);

    always #10 clk = ~clk;

    int vecs = 0, bad = 0;
    int m_cnt, m_awake, m_reload, m_thr, m_ratio;
    bit m_run;

    function automatic logic [WAYS-1:0] bmask(input int n);
        logic [WAYS-1:0] m = '0;
        for (int i = 0; i < WAYS; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic bit exp_expand();
        return (m_cnt < WAYS) && (m_awake >= m_reload ||
               (m_ratio != 0 && m_ratio > m_thr));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (m_run) m_awake++;
    endtask

    task automatic do_entry(input int step, input int thr, input int ratio,
                            input bit keep, input int reload);
        bit go;
        int tgt;
        tgt = (step >= m_cnt) ? 0 : m_cnt - step;
        go = !keep && (m_awake < m_reload) && (ratio == 0 || ratio < thr) && (tgt != m_cnt);
        shrink_step = CNT_W'(step); shrink_thresh = RATIO_W'(thr);
        clk_ratio = RATIO_W'(ratio); keep_full = keep;
        timer_reload = TIMER_W'(reload); sleep_req = 1'b1;
        m_run = 0;
        tick();
        sleep_req = 1'b0; keep_full = 1'b0;
        m_awake = 0; m_thr = thr; m_reload = reload; m_ratio = ratio;
        if (go) begin
            while (m_cnt > tgt) begin
                int idx, d;
                idx = m_cnt - 1;
                chk("R3 flush_req one-hot on top way", 32'(flush_req), 32'(1 << idx));
                d = $urandom % 3;
                repeat (d) begin
                    flush_done = WAYS'($urandom) & ~WAYS'(1 << idx);
                    tick();
                    chk("R3 other done bits ignored", 32'(way_en), 32'(bmask(m_cnt)));
                end
                flush_done = WAYS'(1 << idx) | (WAYS'($urandom) & bmask(idx));
                tick();
                flush_done = '0;
                m_cnt--;
                chk("R3 way dropped after done", 32'(way_en), 32'(bmask(m_cnt)));
            end
        end
        chk("R2 mask after entry", 32'(way_en), 32'(bmask(m_cnt)));
        chk("R3 no flush once asleep", 32'(flush_req), 32'h0);
        chk("R8 deep_ok asleep", 32'(deep_ok), 32'(m_cnt == 0));
        chk("R4 expand_req asleep", 32'(expand_req), 32'(exp_expand()));
    endtask

    task automatic do_wake();
        logic [WAYS-1:0] inv;
        wake = 1'b1;
        tick();
        wake = 1'b0; m_run = 1;
        inv = '0;
        if (m_cnt < 2) begin inv = bmask(2) & ~bmask(m_cnt); m_cnt = 2; end
        chk("R7 mask after wake", 32'(way_en), 32'(bmask(m_cnt)));
        chk("R7 inval pulse on wake", 32'(inval_req), 32'(inv));
        chk("R8 deep_ok low when running", 32'(deep_ok), 32'h0);
        tick();
        chk("R7 inval pulse ends", 32'(inval_req), 32'h0);
    endtask

    task automatic do_irq();
        bit e;
        logic [WAYS-1:0] inv;
        e = m_run && exp_expand();
        inv = '0;
        irq = 1'b1;
        tick();
        irq = 1'b0;
        if (e) begin inv = ~bmask(m_cnt); m_cnt = WAYS; end
        chk("R6 mask after irq", 32'(way_en), 32'(bmask(m_cnt)));
        chk("R6 inval pulse on irq", 32'(inval_req), 32'(inv));
        tick();
        chk("R6 inval pulse ends", 32'(inval_req), 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = WAYS; m_awake = 0; m_reload = TIMER_DEF; m_thr = (1 << RATIO_W) - 1;
        m_ratio = 0; m_run = 0;
        repeat (3) tick();
        rst = 1'b0; m_run = 1;
        tick();
        chk("R1 reset mask", 32'(way_en), 32'(bmask(WAYS)));
        chk("R1 reset flush", 32'(flush_req), 32'h0);
        chk("R1 reset inval", 32'(inval_req), 32'h0);
        chk("R1 reset deep_ok", 32'(deep_ok), 32'h0);
        chk("R1 reset expand", 32'(expand_req), 32'h0);

        do_entry(3, 5, 0, 0, 2000);
        sleep_req = 1'b1; shrink_step = CNT_W'(4);
        tick();
        sleep_req = 1'b0;
        chk("R11 sleep_req ignored asleep mask", 32'(way_en), 32'(bmask(m_cnt)));
        chk("R11 sleep_req ignored asleep flush", 32'(flush_req), 32'h0);
        do_wake();
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk("R11 wake ignored running mask", 32'(way_en), 32'(bmask(m_cnt)));
        chk("R11 wake ignored running inval", 32'(inval_req), 32'h0);

        do_entry(7, 5, 2, 0, 2000);
        chk("R2 saturated to zero", 32'(m_cnt), 32'h0);
        do_wake();
        do_entry(1, 4, 4, 0, 2000);
        do_wake();
        do_entry(1, 4, 9, 0, 2000);
        chk("R4 expand above threshold", 32'(expand_req), 32'h1);
        shrink_thresh = RATIO_W'(20);
        tick();
        chk("R10 threshold change ignored", 32'(expand_req), 32'h1);
        do_wake();
        irq = 1'b1;
        do_entry(0, 20, 9, 0, 2000);
        irq = 1'b0;
        chk("R11 irq dropped at entry", 32'(way_en), 32'(bmask(2)));
        chk("R10 new threshold applied", 32'(expand_req), 32'h0);
        do_wake();
        clk_ratio = RATIO_W'(30); m_ratio = 30;
        tick();
        chk("R4 expand on rising ratio", 32'(expand_req), 32'h1);
        do_irq();
        chk("R6 full restore", 32'(way_en), 32'(bmask(WAYS)));
        clk_ratio = '0; m_ratio = 0;

        do_entry(3, 5, 0, 1, 2000);
        chk("R9 keep_full holds size", 32'(way_en), 32'(bmask(WAYS)));
        chk("R9 keep_full no deep", 32'(deep_ok), 32'h0);
        do_wake();

        do_entry(2, 5, 0, 0, 30);
        do_wake();
        while (m_awake < 29) tick();
        chk("R5 timer not yet expired", 32'(expand_req), 32'h0);
        tick();
        chk("R5 timer expiry raises expand", 32'(expand_req), 32'h1);
        do_entry(2, 5, 0, 0, 30);
        chk("R5 expiry blocked shrink", 32'(way_en), 32'(bmask(6)));
        do_wake();
        do_irq();
        chk("R6 irq without expand ignored", 32'(way_en), 32'(bmask(6)));
        while (m_awake < 30) tick();
        do_irq();
        chk("R5 expiry restores on irq", 32'(way_en), 32'(bmask(WAYS)));

        for (int it = 0; it < 60; it++) begin
            do_entry($urandom % 11, $urandom % 16, $urandom % 16,
                     ($urandom % 8) == 0, 4000);
            do_wake();
            repeat ($urandom % 5) tick();
            if ($urandom % 3 == 0) begin
                clk_ratio = RATIO_W'($urandom % 24); m_ratio = int'(clk_ratio);
                tick();
                chk("R4 expand random", 32'(expand_req), 32'(exp_expand()));
                do_irq();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule